// File: doc/BRIEF.md
# Guarded 32-Pin General-Purpose I/O Port

The block is a 32-pin general-purpose I/O port reached through a simple single-cycle register bus. Software drives the output latch in four ways: a plain write, an atomic set, an atomic clear and an atomic toggle. Each of the set, clear and toggle registers takes a bit mask. A direction register selects which pins drive, and a synchronised copy of the pin levels can be read back. Per-pin event inputs raise sticky flags, which feed one interrupt line. A pin placed in DMA mode has its flag cleared by a completion pulse instead of by software.

Every access to a port register passes through a per-byte access filter. Each of the four data bytes carries a 3-bit attribute code. That code, together with the requester's privilege and security qualifiers, decides whether the byte may be read, written, both, or neither. A bypass bit turns the filter off. Only a privileged secure requester may reach the attribute register.

Bus responses are combinational in the cycle the request is presented. Writes take effect at the next rising clock edge.

Top module: `gpio_guard`

## Requirements
- R1: Reset clears the output latch, direction, flags, DMA-mode bits, attribute codes and bypass, so every pin output, output enable and the interrupt line read 0. Each output enable `pin_oe[n]` follows direction bit n (register address 4): 1 makes the pin an output and 0 makes it an input.
- R2: Address 0 is the output latch and can be read and written. A mask written to address 1 sets the masked latch bits, a mask written to address 2 clears them, and a mask written to address 3 inverts them. Bits outside the mask do not change. Addresses 1 to 3 read as zero. `pin_out` shows the latch one cycle after the write.
- R3: Address 5 returns `pin_in` through a two-flop synchroniser, with pin n at bit n. A level applied before rising edge k is readable after edge k+1. Writes to address 5 change nothing.
- R4: Address 6 holds one flag per pin, and writing 1 to a bit clears that flag. An asserted `evt_in[n]` sets flag n at the next edge. If a software clear and an event hit the same pin in the same cycle, the flag stays set. An event held high therefore sets the flag again straight after a clear.
- R5: Address 7 holds the DMA-mode bits. When a pin is in DMA mode, a `dma_done[n]` pulse clears its flag. For pins not in DMA mode the pulse has no effect.
- R6: `irq` is high while any flag of a pin not in DMA mode is set.
- R7: Requester classes are: privileged secure (`bus_priv`=1, `bus_secure`=1); user secure (`bus_priv`=0, `bus_secure`=1); user non-secure (`bus_secure`=0, either `bus_priv`). Byte k (pins 8k+7..8k) has code k at bits 4k+2..4k of address 8. Privileged secure may read codes 0–6 and write codes 0–5. User secure may read codes 0–4 and write codes 0–2. User non-secure may read codes 0, 1 and 3 and write only code 0.
- R8: A port access (addresses 0–7) that is denied on any byte sets `bus_err`. Denied bytes of a write stay unchanged while allowed bytes are written. This applies to set, clear, toggle and flag-clear masks as well. Denied bytes of a read return zero.
- R9: Bit 16 of address 8 is a bypass. While it is 1, every class may read and write every byte of addresses 0–7 with no error.
- R10: Only a privileged secure requester may read or write address 8. Any other requester gets `bus_err`, reads zero, and leaves the codes and bypass unchanged.
- R11: Addresses 9–15 are unmapped. Accessing them sets `bus_err`, reads zero, and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data or mask |
| bus_priv | input | 1 | Requester is privileged |
| bus_secure | input | 1 | Requester is secure |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | Access denied or unmapped, combinational |
| pin_in | input | 32 | Pin levels, asynchronous |
| pin_out | output | 32 | Output latch values |
| pin_oe | output | 32 | Output enables |
| evt_in | input | 32 | Per-pin event levels |
| dma_done | input | 32 | Per-pin DMA completion pulses |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions are provoked on purpose.

The first puts a software write-one-to-clear of a flag in the same cycle as a new event on that pin. The bench judges it by reading the flag register afterwards and expecting the bit still set. The same check, run with the event held high, confirms the level re-sets the flag.

The second puts a `dma_done` pulse alongside pins in both modes. Only the DMA-mode flag may drop. A behavioural model, compared on every clock, also follows `irq` through these cycles.

// File: rtl/gpio_guard.sv
module gpio_guard #(
  parameter int NPINS = 32,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  input  logic             bus_priv,
  input  logic             bus_secure,
  output logic [NPINS-1:0] bus_rdata,
  output logic             bus_err,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  input  logic [NPINS-1:0] evt_in,
  input  logic [NPINS-1:0] dma_done,
  output logic             irq
);
  localparam int NB  = NPINS / 8;
  localparam int BYP = 4 * NB;
  localparam logic [AW-1:0] A_OUT = AW'(0);
  localparam logic [AW-1:0] A_SET = AW'(1);
  localparam logic [AW-1:0] A_CLR = AW'(2);
  localparam logic [AW-1:0] A_TGL = AW'(3);
  localparam logic [AW-1:0] A_DIR = AW'(4);
  localparam logic [AW-1:0] A_IN  = AW'(5);
  localparam logic [AW-1:0] A_FLG = AW'(6);
  localparam logic [AW-1:0] A_DMA = AW'(7);
  localparam logic [AW-1:0] A_ATR = AW'(8);

  logic [NPINS-1:0] out_q, dir_q, s1_q, s2_q, flag_q, dma_q;
  logic [3*NB-1:0]  code_q;
  logic             byp_q;

  logic             cls_ps, cls_us;
  logic [NB-1:0]    rd_ok, wr_ok;
  logic [NPINS-1:0] rbm, wbm, wm, flg_clr, attr_rd;
  logic             is_attr, mapped, port_ok, wr;

  assign cls_ps = bus_priv & bus_secure;
  assign cls_us = ~bus_priv & bus_secure;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [2:0] c;
    assign c = code_q[3*k +: 3];
    assign rd_ok[k] = byp_q | (cls_ps ? (c != 3'd7) :
                               cls_us ? (c <= 3'd4) :
                               (c == 3'd0 || c == 3'd1 || c == 3'd3));
    assign wr_ok[k] = byp_q | (cls_ps ? (c <= 3'd5) :
                               cls_us ? (c <= 3'd2) : (c == 3'd0));
    assign rbm[8*k +: 8] = {8{rd_ok[k]}};
    assign wbm[8*k +: 8] = {8{wr_ok[k]}};
  end

  always_comb begin
    attr_rd = '0;
    for (int k = 0; k < NB; k++) attr_rd[4*k +: 3] = code_q[3*k +: 3];
    attr_rd[BYP] = byp_q;
  end

  assign is_attr = bus_addr == A_ATR;
  assign mapped  = bus_addr <= A_ATR;
  assign port_ok = bus_write ? &wr_ok : &rd_ok;
  assign bus_err = bus_valid & (~mapped | (is_attr ? ~cls_ps : ~port_ok));
  assign wr      = bus_valid & bus_write;
  assign wm      = bus_wdata & wbm;
  assign flg_clr = (wr && bus_addr == A_FLG) ? wm : '0;

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        A_OUT:   bus_rdata = out_q & rbm;
        A_DIR:   bus_rdata = dir_q & rbm;
        A_IN:    bus_rdata = s2_q & rbm;
        A_FLG:   bus_rdata = flag_q & rbm;
        A_DMA:   bus_rdata = dma_q & rbm;
        A_ATR:   if (cls_ps) bus_rdata = attr_rd;
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      flag_q <= '0;
      dma_q  <= '0;
      code_q <= '0;
      byp_q  <= 1'b0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      flag_q <= (flag_q & ~flg_clr & ~(dma_q & dma_done)) | evt_in;
      if (wr) begin
        case (bus_addr)
          A_OUT: out_q <= (out_q & ~wbm) | wm;
          A_SET: out_q <= out_q | wm;
          A_CLR: out_q <= out_q & ~wm;
          A_TGL: out_q <= out_q ^ wm;
          A_DIR: dir_q <= (dir_q & ~wbm) | wm;
          A_DMA: dma_q <= (dma_q & ~wbm) | wm;
          A_ATR: if (cls_ps) begin
            for (int k = 0; k < NB; k++) code_q[3*k +: 3] <= bus_wdata[4*k +: 3];
            byp_q <= bus_wdata[BYP];
          end
          default: ;
        endcase
      end
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(flag_q & ~dma_q);
endmodule

// File: rtl/gpio_guard_chk.sv
module gpio_guard_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic             bus_priv,
  input logic             bus_secure,
  input logic             bus_err,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] evt_in,
  input logic [NPINS-1:0] dma_done,
  input logic [NPINS-1:0] flag_q,
  input logic [3*(NPINS/8)-1:0] code_q,
  input logic             byp_q
);
  localparam logic [AW-1:0] C_SET = AW'(1);
  localparam logic [AW-1:0] C_CLR = AW'(2);
  localparam logic [AW-1:0] C_ATR = AW'(8);

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr == C_SET && !bus_err
    |=> (pin_out & $past(bus_wdata)) == $past(bus_wdata));

  assert_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr == C_CLR && !bus_err
    |=> (pin_out & $past(bus_wdata)) == '0);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> $stable(pin_out));

  assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    |evt_in |=> (flag_q & $past(evt_in)) == $past(evt_in));

  assert_flag_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid && evt_in == '0 && dma_done == '0 |=> $stable(flag_q));

  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && byp_q && bus_addr < C_ATR |-> !bus_err);

  assert_attr_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr == C_ATR && !(bus_priv && bus_secure)
    |=> $stable(code_q) && $stable(byp_q));

  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_addr > C_ATR |-> bus_err);
endmodule

bind gpio_guard gpio_guard_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
  .bus_secure(bus_secure), .bus_err(bus_err), .pin_out(pin_out),
  .evt_in(evt_in), .dma_done(dma_done), .flag_q(flag_q),
  .code_q(code_q), .byp_q(byp_q)
);

// File: tb/gpio_guard_bench.sv
`timescale 1ns/1ps
module gpio_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_priv = 1'b0, bus_secure = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0, evt_in = '0, dma_done = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic        bus_err, irq;

  always #2.5 clk = ~clk;

  gpio_guard u_gpio_guard (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
    .bus_secure(bus_secure), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .evt_in(evt_in),
    .dma_done(dma_done), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_out = '0, m_dir = '0, m_flag = '0, m_dma = '0, m_s1 = '0, m_s2 = '0;
  logic [2:0]  m_code [4] = '{3'd0, 3'd0, 3'd0, 3'd0};
  logic        m_byp = 1'b0;
  logic [31:0] g_ev = '0, g_dm = '0, g_pin = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit rok(input int c, input bit p, input bit s);
    if (p && s) return c != 7;
    if (s) return c <= 4;
    return c == 0 || c == 1 || c == 3;
  endfunction

  function automatic bit wok(input int c, input bit p, input bit s);
    if (p && s) return c <= 5;
    if (s) return c <= 2;
    return c == 0;
  endfunction

  task automatic cyc(input bit v, input bit w, input int a, input logic [31:0] d,
                     input bit p, input bit s, input string tag);
    logic [31:0] rb, wb, wm, er, clr;
    bit allr, allw, e_err;
    @(negedge clk);
    chk("R2", pin_out, m_out);
    chk("R1", pin_oe, m_dir);
    chk("R6", {31'b0, irq}, {31'b0, |(m_flag & ~m_dma)});
    bus_valid = v; bus_write = w; bus_addr = a[3:0]; bus_wdata = d;
    bus_priv = p; bus_secure = s; evt_in = g_ev; dma_done = g_dm; pin_in = g_pin;
    #1;
    rb = '0; wb = '0; allr = 1; allw = 1;
    for (int k = 0; k < 4; k++) begin
      if (m_byp || rok(m_code[k], p, s)) rb[8*k +: 8] = 8'hFF; else allr = 0;
      if (m_byp || wok(m_code[k], p, s)) wb[8*k +: 8] = 8'hFF; else allw = 0;
    end
    if (!v) e_err = 0;
    else if (a > 8) e_err = 1;
    else if (a == 8) e_err = !(p && s);
    else e_err = w ? !allw : !allr;
    er = '0;
    if (v && !w) begin
      case (a)
        0: er = m_out & rb;
        4: er = m_dir & rb;
        5: er = m_s2 & rb;
        6: er = m_flag & rb;
        7: er = m_dma & rb;
        8: if (p && s) begin
             for (int k = 0; k < 4; k++) er[4*k +: 3] = m_code[k];
             er[16] = m_byp;
           end
        default: er = '0;
      endcase
    end
    chk(tag, bus_rdata, er);
    chk(tag, {31'b0, bus_err}, {31'b0, e_err});
    wm  = d & wb;
    clr = (v && w && a == 6) ? wm : '0;
    m_s2 = m_s1; m_s1 = g_pin;
    m_flag = (m_flag & ~clr & ~(m_dma & g_dm)) | g_ev;
    if (v && w) begin
      case (a)
        0: m_out = (m_out & ~wb) | wm;
        1: m_out = m_out | wm;
        2: m_out = m_out & ~wm;
        3: m_out = m_out ^ wm;
        4: m_dir = (m_dir & ~wb) | wm;
        7: m_dma = (m_dma & ~wb) | wm;
        8: if (p && s) begin
             for (int k = 0; k < 4; k++) m_code[k] = d[4*k +: 3];
             m_byp = d[16];
           end
        default: ;
      endcase
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input bit p, input bit s, input string tag);
    cyc(1, 1, a, d, p, s, tag);
  endtask
  task automatic rd(input int a, input bit p, input bit s, input string tag);
    cyc(1, 0, a, '0, p, s, tag);
  endtask
  task automatic idle(input string tag);
    cyc(0, 0, 0, '0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    idle("R1"); rd(0, 1, 1, "R1"); rd(4, 1, 1, "R1"); rd(8, 1, 1, "R1");
    // R1 direction, R2 latch operations
    wr(4, 32'hFFFF00FF, 1, 1, "R1");
    wr(0, 32'h12345678, 1, 1, "R2");
    wr(1, 32'h0000FF00, 1, 1, "R2");
    wr(2, 32'h0000000F, 1, 1, "R2");
    wr(3, 32'hF0F0F0F0, 1, 1, "R2");
    rd(0, 1, 1, "R2"); rd(1, 1, 1, "R2"); rd(3, 1, 1, "R2"); rd(4, 1, 1, "R1");
    // R3 synchroniser latency and ignored writes
    g_pin = 32'hA5A50F0F;
    rd(5, 1, 1, "R3"); rd(5, 1, 1, "R3"); rd(5, 1, 1, "R3"); rd(5, 1, 1, "R3");
    g_pin = 32'h3C3C_C3C3;
    wr(5, 32'hFFFFFFFF, 1, 1, "R3");
    rd(5, 1, 1, "R3"); rd(5, 1, 1, "R3"); rd(5, 1, 1, "R3");
    // R4 flags: set, w1c, collision, held level
    g_ev = 32'h00000011; idle("R4"); g_ev = '0;
    rd(6, 1, 1, "R4");
    wr(6, 32'h00000001, 1, 1, "R4"); rd(6, 1, 1, "R4");
    g_ev = 32'h00000010; wr(6, 32'h00000010, 1, 1, "R4"); g_ev = '0;
    rd(6, 1, 1, "R4");
    g_ev = 32'h00000100; wr(6, 32'h00000100, 1, 1, "R4"); rd(6, 1, 1, "R4");
    g_ev = '0; wr(6, 32'hFFFFFFFF, 1, 1, "R4"); rd(6, 1, 1, "R4");
    // R5 DMA auto-clear, R6 interrupt masking
    wr(7, 32'h00000002, 1, 1, "R5");
    g_ev = 32'h00000006; idle("R6"); g_ev = '0; idle("R6");
    g_dm = 32'h00000006; idle("R5"); g_dm = '0;
    rd(6, 1, 1, "R5");
    wr(6, 32'h00000004, 1, 1, "R6"); idle("R6");
    g_ev = 32'h00000002; idle("R6"); g_ev = '0; idle("R6"); rd(6, 1, 1, "R6");
    g_dm = 32'h00000002; idle("R5"); g_dm = '0; rd(6, 1, 1, "R5");
    wr(7, 32'h0, 1, 1, "R5");
    // R7 full code table for every class
    for (int c = 0; c < 8; c++) begin
      for (int cl = 0; cl < 4; cl++) begin
        bit p, s;
        p = (cl == 2) || (cl == 3);
        s = (cl == 1) || (cl == 2);
        wr(8, 32'h00001111 * c, 1, 1, "R7");
        wr(0, 32'h01010101 * (c * 4 + cl + 1), p, s, "R7");
        rd(0, p, s, "R7");
        wr(1, 32'h80808080, p, s, "R7");
        rd(0, 1, 1, "R7");
      end
    end
    // R8 mixed per-byte codes
    wr(8, 32'h00007520, 1, 1, "R8");
    wr(0, 32'h00000000, 1, 1, "R8");
    wr(0, 32'hFFFFFFFF, 0, 1, "R8"); rd(0, 0, 1, "R8"); rd(0, 1, 1, "R8");
    wr(2, 32'hFFFFFFFF, 1, 1, "R8"); rd(0, 0, 1, "R8");
    g_ev = 32'hFFFFFFFF; idle("R8"); g_ev = '0;
    wr(6, 32'hFFFFFFFF, 0, 0, "R8"); rd(6, 1, 1, "R8");
    wr(6, 32'hFFFFFFFF, 1, 1, "R8"); rd(6, 0, 1, "R8");
    // R9 bypass
    wr(8, 32'h00017777, 1, 1, "R9");
    wr(0, 32'hCAFEF00D, 0, 0, "R9"); rd(0, 0, 0, "R9"); rd(4, 1, 0, "R9");
    // R10 attribute register protection
    wr(8, 32'h00000000, 0, 1, "R10"); rd(8, 0, 1, "R10"); rd(8, 1, 0, "R10");
    rd(8, 1, 1, "R10"); rd(0, 0, 0, "R10");
    wr(8, 32'h00000000, 1, 1, "R10"); rd(8, 1, 1, "R10");
    // R11 unmapped
    rd(12, 1, 1, "R11"); wr(15, 32'hFFFFFFFF, 1, 1, "R11"); rd(9, 0, 0, "R11");
    rd(0, 1, 1, "R11");
    idle("R2"); idle("R2");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule